// File: doc/BRIEF.md
# DMA Request and Byte-Count Controller

This block sits between a controller's packet buffers and an external system DMA engine. Software programs an 8-bit configuration byte that picks the transfer direction, the target buffer, the burst size and whether a byte counter is used. It can also load a byte count. Once the enable bit is set, the block raises a request toward the DMA engine. Every acknowledge it accepts moves one 16-bit word to or from the selected buffer, which is signalled by a one-cycle buffer strobe.

When the counter is in use, each accepted word lowers the remaining count by two bytes. When the count runs out, the block withdraws its request, clears its own enable bit and pulses a done interrupt. When the counter is off, bursts repeat until software clears the enable bit.

A shared-channel input lets a second client, the peripheral side, use the same request/acknowledge pair. On that pair the request is active high and the acknowledge is active low. Arbitration uses fixed priority, with the host side first.

Top module: `dma_req_ctrl`

## Requirements
- R1: After reset the configuration byte and the byte count read as zero. `sys_dreq` and `done_irq` are low and `periph_dack_n` is high.
- R2: Configuration bit 0 gives the direction and drives `buf_wr` (1 = write into the buffer, 0 = read from it).
- R3: Configuration bits 3:1 hold a buffer code. Codes 0, 1, 2 and 3 (isochronous list 0, isochronous list 1, asynchronous list, interrupt list) assert `buf_sel` bit 0, 1, 2 and 3 respectively. Codes 4 to 7 select no buffer, and the block then never requests, even when enabled.
- R4: In dual-channel mode (`one_chan` = 0) with a valid buffer, `sys_dreq` is high in the cycle that directly follows the clock edge on which configuration bit 4 (enable) is written as 1. This holds when the counter is off or the count is nonzero.
- R5: Configuration bits 6:5 set the burst: codes 0, 1, 2 and 3 give 1, 4, 8 and 16 words. After the last accepted word of a burst the request is low for exactly one cycle and then rises again if work remains.
- R6: With configuration bit 7 set, each accepted word lowers `cnt_q` by 2, saturating at zero. On the word that brings the count to zero, the enable bit clears, `sys_dreq` drops and `done_irq` is high for exactly one cycle.
- R7: With configuration bit 7 clear, `cnt_q` is untouched and bursts repeat until software writes the enable bit to 0. The request then drops in the next cycle.
- R8: With the counter on and a count of zero, setting the enable bit produces no request.
- R9: In dual-channel mode `periph_dreq` is ignored and `periph_dack_n` stays high. In shared-channel mode an idle host lets `periph_dreq` reach `sys_dreq`, and a low `sys_dack_n` is passed to `periph_dack_n`.
- R10: In shared-channel mode a host request wins over a simultaneous peripheral request. The peripheral receives no acknowledge until the host grant ends.
- R11: An acknowledge while the host request is low (disabled, gap cycle or peripheral grant) produces no `buf_stb` and leaves `cnt_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| one_chan | input | 1 | 1 = both clients share the sys DREQ/DACK pair |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte to write |
| cnt_wr | input | 1 | Write strobe for the byte count |
| cnt_wdata | input | CNT_W | Byte count to write |
| cfg_q | output | 8 | Current configuration byte |
| cnt_q | output | CNT_W | Remaining byte count |
| sys_dreq | output | 1 | Request to the DMA engine, active high |
| sys_dack_n | input | 1 | Acknowledge from the DMA engine, active low |
| periph_dreq | input | 1 | Peripheral-side request, active high |
| periph_dack_n | output | 1 | Acknowledge routed to the peripheral side, active low |
| buf_sel | output | 4 | One-hot target buffer |
| buf_wr | output | 1 | Transfer direction |
| buf_stb | output | 1 | One word moved this cycle |
| done_irq | output | 1 | One-cycle pulse when the count is exhausted |

## Verification
The assertions cover every cycle. They check that the request drops in the cycle after a burst's last word and that a done pulse coincides with a cleared enable. They also check that at most one client sees an acknowledge at a time, that the peripheral acknowledge stays idle in dual-channel mode, and that no word strobe happens without a live request. Other behaviours depend on a chosen configuration, so only the directed scenarios can show them: the exact burst length for each code, the count reaching zero on odd and even starts, the host winning a tie with the peripheral, and the request rising in the first cycle after enable.

// File: rtl/dmac_pkg.sv
// Shared types and helpers for the DMA request controller.
// Assumes the configuration byte layout used by software is fixed as below.
package dmac_pkg;
    localparam int CFG_W  = 8;
    localparam int BUF_N  = 4;
    localparam int BEAT_W = 5;

    // Configuration byte, MSB first: counter enable, burst code, enable, buffer code, direction.
    typedef struct packed {
        logic       cnt_en;
        logic [1:0] burst;
        logic       en;
        logic [2:0] buf_code;
        logic       dir;
    } cfg_t;

    typedef enum logic [1:0] {GNT_NONE, GNT_HOST, GNT_PERIPH} gnt_e;

    // Words per request for a 2-bit burst code.
    function automatic logic [BEAT_W-1:0] burst_words(input logic [1:0] code);
        case (code)
            2'd0:    burst_words = BEAT_W'(1);
            2'd1:    burst_words = BEAT_W'(4);
            2'd2:    burst_words = BEAT_W'(8);
            default: burst_words = BEAT_W'(16);
        endcase
    endfunction
endpackage

// File: rtl/dmac_cfg_regs.sv
// Configuration byte and byte counter.
// Counts down by two on each word strobe when the counter is enabled; on
// exhaustion clears the enable bit and pulses done. Software writes win
// over hardware updates in the same cycle.
module dmac_cfg_regs
    import dmac_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             word_stb,
    output cfg_t             cfg_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             done_q
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(2);

    // Register update: hardware countdown, then software writes override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (word_stb && cfg_q.cnt_en) begin
                if (cnt_q <= STEP) begin
                    cnt_q    <= '0;
                    cfg_q.en <= 1'b0;
                    done_q   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - STEP;
                end
            end
            if (cfg_wr) cfg_q <= cfg_t'(cfg_wdata);
            if (cnt_wr) cnt_q <= cnt_wdata;
        end
    end

    AST_DONE_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!cfg_q.en || $past(cfg_wr))); // R6
endmodule

// File: rtl/dmac_burst_engine.sv
// Host-side request generator.
// Raises the host request while enabled with a valid buffer and work left,
// counts accepted words per burst, and inserts a one-cycle gap after the
// last word of each burst. Assumes dack_ok is already routed to this client.
module dmac_burst_engine
    import dmac_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cfg_wr,
    input  logic             dack_ok,
    output logic             host_req,
    output logic             word_stb,
    output logic [BUF_N-1:0] buf_sel
);
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] burst_len;
    logic              gap_q;
    logic              buf_ok;
    logic              last_beat;

    // One select line per buffer kind.
    for (genvar i = 0; i < BUF_N; i++) begin : g_sel
        assign buf_sel[i] = (cfg.buf_code == 3'(i));
    end

    assign buf_ok    = |buf_sel;
    assign host_req  = cfg.en && buf_ok && (!cfg.cnt_en || (cnt != '0)) && !gap_q;
    assign word_stb  = dack_ok && host_req;
    assign burst_len = burst_words(cfg.burst);
    assign last_beat = word_stb && (beat_q == burst_len - BEAT_W'(1));

    // Beat position within a burst and the gap after its final word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
            gap_q  <= 1'b0;
        end else begin
            gap_q <= last_beat;
            if (cfg_wr || last_beat) beat_q <= '0;
            else if (word_stb)       beat_q <= beat_q + BEAT_W'(1);
        end
    end

    AST_GAP_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> !host_req); // R5
    AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        beat_q < burst_len || $past(cfg_wr)); // R5
endmodule

// File: rtl/dmac_chan_arb.sv
// Request/acknowledge routing for dual or shared channel use.
// Dual mode: the sys pair belongs to the host. Shared mode: a registered
// fixed-priority grant (host first) held until the winner drops its request.
module dmac_chan_arb
    import dmac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic one_chan,
    input  logic host_req,
    input  logic periph_req,
    input  logic sys_dack_n,
    output logic sys_dreq,
    output logic host_dack_ok,
    output logic periph_dack_n
);
    gnt_e gnt_q;

    // Grant state: pick a winner when free, release when it goes quiet.
    always_ff @(posedge clk) begin
        if (!rst_n || !one_chan) begin
            gnt_q <= GNT_NONE;
        end else begin
            case (gnt_q)
                GNT_NONE: begin
                    if (host_req)        gnt_q <= GNT_HOST;
                    else if (periph_req) gnt_q <= GNT_PERIPH;
                end
                GNT_HOST:   if (!host_req)   gnt_q <= GNT_NONE;
                GNT_PERIPH: if (!periph_req) gnt_q <= GNT_NONE;
                default:    gnt_q <= GNT_NONE;
            endcase
        end
    end

    // Route the request out and the acknowledge back to the granted client.
    always_comb begin
        if (one_chan) begin
            sys_dreq      = ((gnt_q == GNT_HOST) && host_req) ||
                            ((gnt_q == GNT_PERIPH) && periph_req);
            host_dack_ok  = (gnt_q == GNT_HOST) && !sys_dack_n;
            periph_dack_n = !((gnt_q == GNT_PERIPH) && !sys_dack_n);
        end else begin
            sys_dreq      = host_req;
            host_dack_ok  = !sys_dack_n;
            periph_dack_n = 1'b1;
        end
    end

    AST_ONE_ACK_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_dack_ok, !periph_dack_n})); // R10
    AST_PERIPH_IDLE_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !one_chan |-> periph_dack_n); // R9
endmodule

// File: rtl/dma_req_ctrl.sv
// DMA request and byte-count controller, top level.
// Joins the configuration/counter registers, the host burst engine and the
// channel arbiter. Assumes one 16-bit word moves per accepted acknowledge.
module dma_req_ctrl
    import dmac_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             one_chan,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_wdata,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [7:0]       cfg_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             sys_dreq,
    input  logic             sys_dack_n,
    input  logic             periph_dreq,
    output logic             periph_dack_n,
    output logic [3:0]       buf_sel,
    output logic             buf_wr,
    output logic             buf_stb,
    output logic             done_irq
);
    cfg_t cfg_s;
    logic host_req;
    logic host_dack_ok;

    dmac_cfg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .word_stb(buf_stb),
        .cfg_q(cfg_s), .cnt_q(cnt_q), .done_q(done_irq)
    );

    dmac_burst_engine #(.CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .cfg(cfg_s), .cnt(cnt_q), .cfg_wr(cfg_wr),
        .dack_ok(host_dack_ok),
        .host_req(host_req), .word_stb(buf_stb), .buf_sel(buf_sel)
    );

    dmac_chan_arb u_arb (
        .clk(clk), .rst_n(rst_n), .one_chan(one_chan),
        .host_req(host_req), .periph_req(periph_dreq),
        .sys_dack_n(sys_dack_n),
        .sys_dreq(sys_dreq), .host_dack_ok(host_dack_ok),
        .periph_dack_n(periph_dack_n)
    );

    assign cfg_q  = cfg_s;
    assign buf_wr = cfg_s.dir;

    AST_DREQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!one_chan && sys_dreq) |-> cfg_q[4]); // R4
    AST_STB_NEEDS_DREQ: assert property (@(posedge clk) disable iff (!rst_n)
        buf_stb |-> (sys_dreq && !sys_dack_n)); // R11
endmodule

// File: tb/dma_req_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module dma_req_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n, one_chan, cfg_wr, cnt_wr, sys_dack_n, periph_dreq;
    logic [7:0]       cfg_wdata, cfg_q;
    logic [CNT_W-1:0] cnt_wdata, cnt_q;
    logic             sys_dreq, periph_dack_n, buf_wr, buf_stb, done_irq;
    logic [3:0]       buf_sel;

    int checks = 0;
    int fails  = 0;
    int stb_seen, periph_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_req_ctrl #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .one_chan(one_chan),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cfg_q(cfg_q), .cnt_q(cnt_q), .sys_dreq(sys_dreq),
        .sys_dack_n(sys_dack_n), .periph_dreq(periph_dreq),
        .periph_dack_n(periph_dack_n), .buf_sel(buf_sel), .buf_wr(buf_wr),
        .buf_stb(buf_stb), .done_irq(done_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input logic ce, input logic [1:0] bc,
                                      input logic en, input logic [2:0] bf, input logic dr);
        return {ce, bc, en, bf, dr};
    endfunction

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic write_cfg(input logic [7:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic write_cnt(input logic [CNT_W-1:0] v);
        cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    // Hold the acknowledge low for n edges, counting strobes and peripheral acks.
    task automatic pulse_dack(input int n);
        stb_seen = 0; periph_seen = 0;
        for (int i = 0; i < n; i++) begin
            sys_dack_n = 1'b0;
            #1;
            if (buf_stb) stb_seen++;
            if (!periph_dack_n) periph_seen++;
            @(negedge clk);
        end
        sys_dack_n = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; one_chan = 1'b0; cfg_wr = 1'b0; cnt_wr = 1'b0;
        cfg_wdata = '0; cnt_wdata = '0; sys_dack_n = 1'b1; periph_dreq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 cfg", cfg_q, 0);
        check("R1 cnt", cnt_q, 0);
        check("R1 dreq", sys_dreq, 0);
        check("R1 done", done_irq, 0);
        check("R1 pdack", periph_dack_n, 1);
    endtask

    task automatic t_select();
        write_cfg(mk(0, 0, 0, 3'd2, 1));
        check("R2 dir", buf_wr, 1);
        check("R3 sel2", buf_sel, 4'b0100);
        write_cfg(mk(0, 0, 0, 3'd3, 0));
        check("R2 dir0", buf_wr, 0);
        check("R3 sel3", buf_sel, 4'b1000);
        write_cfg(mk(0, 0, 1, 3'd5, 0));
        check("R3 bad code sel", buf_sel, 0);
        check("R3 bad code dreq", sys_dreq, 0);
        write_cfg(8'h00);
    endtask

    task automatic t_bursts();
        int words [4] = '{1, 4, 8, 16};
        for (int c = 0; c < 4; c++) begin
            write_cfg(mk(0, 2'(c), 1, 3'd0, 0));
            check("R4 dreq on enable", sys_dreq, 1);
            if (words[c] > 1) begin
                pulse_dack(words[c] - 1);
                check("R5 mid burst dreq", sys_dreq, 1);
            end
            pulse_dack(1);
            check("R5 gap dreq", sys_dreq, 0);
            @(negedge clk);
            check("R5 re-request", sys_dreq, 1);
            check("R7 cnt untouched", cnt_q, 0);
            write_cfg(8'h00);
            check("R7 disable drops dreq", sys_dreq, 0);
        end
    endtask

    task automatic t_counter();
        write_cnt(16'd6);
        write_cfg(mk(1, 2'd3, 1, 3'd1, 0));
        pulse_dack(2);
        check("R6 cnt step", cnt_q, 2);
        check("R6 no early done", done_irq, 0);
        pulse_dack(1);
        check("R6 cnt zero", cnt_q, 0);
        check("R6 done", done_irq, 1);
        check("R6 en cleared", cfg_q[4], 0);
        check("R6 dreq low", sys_dreq, 0);
        @(negedge clk);
        check("R6 done one cycle", done_irq, 0);
        write_cnt(16'd3);
        write_cfg(mk(1, 2'd3, 1, 3'd0, 0));
        pulse_dack(1);
        check("R6 odd step", cnt_q, 1);
        pulse_dack(1);
        check("R6 odd saturate", cnt_q, 0);
        check("R6 odd done", done_irq, 1);
    endtask

    task automatic t_zero_count();
        write_cfg(mk(1, 2'd1, 1, 3'd0, 0));
        check("R8 no request", sys_dreq, 0);
        pulse_dack(2);
        check("R11 no strobe", stb_seen, 0);
        check("R8 no done", done_irq, 0);
        write_cfg(8'h00);
    endtask

    task automatic t_continuous();
        write_cfg(mk(0, 2'd0, 1, 3'd2, 1));
        pulse_dack(6);
        check("R11 gap ignores dack", stb_seen, 3);
        check("R7 still requesting", sys_dreq, 1);
        write_cfg(mk(0, 2'd0, 0, 3'd2, 1));
        check("R7 stop", sys_dreq, 0);
        pulse_dack(2);
        check("R11 disabled ignores dack", stb_seen, 0);
        check("R11 cnt kept", cnt_q, 0);
    endtask

    task automatic t_dual_periph();
        periph_dreq = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R9 dual ignores preq", sys_dreq, 0);
        pulse_dack(2);
        check("R9 dual no pdack", periph_seen, 0);
        periph_dreq = 1'b0;
    endtask

    task automatic t_single_periph();
        one_chan = 1'b1; periph_dreq = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R9 shared forwards preq", sys_dreq, 1);
        pulse_dack(2);
        check("R9 shared pdack", periph_seen, 2);
        check("R11 periph grant no strobe", stb_seen, 0);
        periph_dreq = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R9 shared release", sys_dreq, 0);
    endtask

    task automatic t_priority();
        write_cnt(16'd8);
        write_cfg(mk(1, 2'd1, 1, 3'd0, 0));
        periph_dreq = 1'b1;
        @(negedge clk);
        check("R10 host wins", sys_dreq, 1);
        pulse_dack(4);
        check("R10 host words", stb_seen, 4);
        check("R10 periph held off", periph_seen, 0);
        check("R10 host done", done_irq, 1);
        repeat (3) @(negedge clk);
        check("R10 periph after host", sys_dreq, 1);
        pulse_dack(1);
        check("R10 periph ack", periph_seen, 1);
        periph_dreq = 1'b0; one_chan = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_select();
        t_bursts();
        t_counter();
        t_zero_count();
        t_continuous();
        t_dual_periph();
        t_single_periph();
        t_priority();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule